// File: doc/BRIEF.md
# Host Command Parser with Register Bank

This block connects the byte-wide FIFO side of a USB bridge chip to a bank of addressed configuration and data registers inside an FPGA. A host packet is a one-byte opcode followed by its operands. The block waits until the bridge reports a waiting byte and pops the packet one byte at a time. It checks the opcode and the target address. A write packet stores one byte into the bank. A read packet sends one byte back to the bridge.

When no host packet is waiting, the same control machine drains an analog-to-digital sample FIFO toward the host. It sends one sample per cycle for as long as the bridge can accept them. A host packet that arrives during draining takes over. Draining continues once the command is finished.

The register space has five windows. There is a general window, and each of two channels has one window the host reads and one window the host writes. The user logic of each channel fills its host-read window and reads its host-write window through a small side port. Bit 0 of general registers 0 and 1 drives the two channel enable outputs.

Top module: `host_cmd_regbank`

## Requirements
- R1: Opcode 8'h01 is a write packet of three bytes: opcode, address, data. Opcode 8'h02 is a read packet of two bytes: opcode, address. Each read packet produces exactly one byte on tx_data, strobed by tx_wr.
- R2: With the default sizes, host writes reach and can be read back at addresses 0–27 (general), 53–77 (channel 1 host-write window) and 103–127 (channel 2 host-write window).
- R3: A host write to 28–52 or 78–102 (channel host-read windows), or to an address of 128 or above, leaves every register unchanged and sets addr_err. addr_err stays set until reset. A read of an address of 128 or above returns 8'h00.
- R4: Any other opcode sets op_err, which stays set until reset. The block then pops bridge bytes until rx_not_empty falls and returns to idle, and no register changes.
- R5: rx_rd is a one-cycle pop that is asserted only while rx_not_empty is high. The byte popped is the one presented on rx_data in that same cycle.
- R6: tx_wr is asserted only while tx_full is low. A read response waits, unchanged, until tx_full falls.
- R7: When idle with no host byte waiting and smp_not_empty high, the block pops samples with smp_rd and writes them to tx_data in the same cycle, in FIFO order.
- R8: While rx_not_empty is high, no sample is popped. A pending host command is served before any further sample, and draining resumes afterwards.
- R9: chan_en[0] equals bit 0 of register 0, and chan_en[1] equals bit 0 of register 1.
- R10: The usr_we pulse writes usr_wdata to the host-read window of channel usr_ch (0 = channel 1, 1 = channel 2) at offset usr_idx. usr_rdata shows the host-write window of channel usr_ch at offset usr_idx. An offset of 25 or more writes nothing and reads 8'h00.
- R11: Reset clears all registers, addr_err, op_err and chan_en, and leaves rx_rd, tx_wr and smp_rd low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_not_empty | input | 1 | Bridge holds at least one host byte |
| rx_data | input | 8 | Head byte of the bridge receive FIFO |
| rx_rd | output | 1 | Pop one host byte |
| tx_full | input | 1 | Bridge transmit FIFO cannot accept a byte |
| tx_data | output | 8 | Byte toward the host |
| tx_wr | output | 1 | Push tx_data into the bridge |
| smp_not_empty | input | 1 | Converter sample FIFO holds data |
| smp_data | input | 8 | Head sample of the converter FIFO |
| smp_rd | output | 1 | Pop one sample |
| usr_we | input | 1 | User write into a channel host-read window |
| usr_ch | input | 1 | Channel select for the user port |
| usr_idx | input | 5 | Offset inside the channel window |
| usr_wdata | input | 8 | User write data |
| usr_rdata | output | 8 | Host-write window contents at the offset |
| chan_en | output | 2 | Channel enables |
| addr_err | output | 1 | Sticky illegal write address flag |
| op_err | output | 1 | Sticky unknown opcode flag |

## Verification
The bench uses the default sizes: a 28-entry general window and 25-entry channel windows, so the bank has 128 registers. With these sizes every window edge can be reached with an 8-bit address: 27/28, 52/53, 77/78, 102/103, and 127 against an address past the bank. The 5-bit offset also reaches the first value past a window, 25, which exercises the offset guard on the user port.

// File: rtl/hcr_pkg.sv
package hcr_pkg;

    localparam int BYTE_W = 8;

    localparam logic [BYTE_W-1:0] OP_WR = 8'h01;
    localparam logic [BYTE_W-1:0] OP_RD = 8'h02;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_TAKE_OP,
        ST_DECIDE,
        ST_GET_ADDR,
        ST_GET_DATA,
        ST_WR_REG,
        ST_RD_REG,
        ST_SEND,
        ST_FLUSH,
        ST_DRAIN
    } ctrl_st_e;

    typedef enum logic [2:0] {
        RG_GEN,
        RG_C1_HRD,
        RG_C1_HWR,
        RG_C2_HRD,
        RG_C2_HWR,
        RG_NONE
    } region_e;

    typedef struct packed {
        ctrl_st_e          st;
        logic [BYTE_W-1:0] opc;
        logic [BYTE_W-1:0] addr;
        logic [BYTE_W-1:0] wdata;
        logic [BYTE_W-1:0] rdata;
        logic              addr_err;
        logic              op_err;
    } ctrl_s;

endpackage

// File: rtl/hcr_region_decode.sv
module hcr_region_decode
    import hcr_pkg::*;
#(
    parameter int GEN_N = 28,
    parameter int WIN_N = 25
) (
    input  logic [BYTE_W-1:0] addr,
    output logic              host_wr_ok
);

    localparam logic [BYTE_W-1:0] B_C1_HRD = BYTE_W'(GEN_N);
    localparam logic [BYTE_W-1:0] B_C1_HWR = BYTE_W'(GEN_N + WIN_N);
    localparam logic [BYTE_W-1:0] B_C2_HRD = BYTE_W'(GEN_N + 2 * WIN_N);
    localparam logic [BYTE_W-1:0] B_C2_HWR = BYTE_W'(GEN_N + 3 * WIN_N);
    localparam logic [BYTE_W-1:0] B_END    = BYTE_W'(GEN_N + 4 * WIN_N);

    region_e region;

    always_comb begin
        if (addr < B_C1_HRD) begin
            region = RG_GEN;
        end else if (addr < B_C1_HWR) begin
            region = RG_C1_HRD;
        end else if (addr < B_C2_HRD) begin
            region = RG_C1_HWR;
        end else if (addr < B_C2_HWR) begin
            region = RG_C2_HRD;
        end else if (addr < B_END) begin
            region = RG_C2_HWR;
        end else begin
            region = RG_NONE;
        end
    end

    always_comb begin
        case (region)
            RG_GEN, RG_C1_HWR, RG_C2_HWR: host_wr_ok = 1'b1;
            default:                      host_wr_ok = 1'b0;
        endcase
    end

endmodule

// File: rtl/hcr_regfile.sv
module hcr_regfile
    import hcr_pkg::*;
#(
    parameter int GEN_N  = 28,
    parameter int WIN_N  = 25,
    parameter int NUM_CH = 2,
    parameter int IDX_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_we,
    input  logic [BYTE_W-1:0] host_addr,
    input  logic [BYTE_W-1:0] host_wdata,
    output logic [BYTE_W-1:0] host_rdata,
    input  logic              usr_we,
    input  logic              usr_ch,
    input  logic [IDX_W-1:0]  usr_idx,
    input  logic [BYTE_W-1:0] usr_wdata,
    output logic [BYTE_W-1:0] usr_rdata,
    output logic [NUM_CH-1:0] chan_en
);

    localparam int NUM_REGS = GEN_N + 4 * WIN_N;
    localparam int RA_W     = $clog2(NUM_REGS);

    localparam logic [RA_W-1:0]   C1_HRD_R = RA_W'(GEN_N);
    localparam logic [RA_W-1:0]   C1_HWR_R = RA_W'(GEN_N + WIN_N);
    localparam logic [RA_W-1:0]   C2_HRD_R = RA_W'(GEN_N + 2 * WIN_N);
    localparam logic [RA_W-1:0]   C2_HWR_R = RA_W'(GEN_N + 3 * WIN_N);
    localparam logic [BYTE_W-1:0] END_B    = BYTE_W'(NUM_REGS);
    localparam logic [IDX_W:0]    WIN_LIM  = (IDX_W + 1)'(WIN_N);

    logic [BYTE_W-1:0] regs_q [NUM_REGS];
    logic [BYTE_W-1:0] regs_d [NUM_REGS];

    logic [RA_W-1:0] host_ra;
    logic [RA_W-1:0] usr_wa;
    logic [RA_W-1:0] usr_ra;
    logic            usr_idx_ok;

    assign host_ra    = host_addr[RA_W-1:0];
    assign usr_idx_ok = ({1'b0, usr_idx} < WIN_LIM);
    assign usr_wa     = (usr_ch ? C2_HRD_R : C1_HRD_R) + RA_W'(usr_idx);
    assign usr_ra     = (usr_ch ? C2_HWR_R : C1_HWR_R) + RA_W'(usr_idx);

    always_comb begin
        regs_d = regs_q;
        if (host_we && (host_addr < END_B)) begin
            regs_d[host_ra] = host_wdata;
        end
        if (usr_we && usr_idx_ok) begin
            regs_d[usr_wa] = usr_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_REGS; i++) begin
                regs_q[i] <= '0;
            end
        end else begin
            regs_q <= regs_d;
        end
    end

    assign host_rdata = (host_addr < END_B) ? regs_q[host_ra] : '0;
    assign usr_rdata  = usr_idx_ok ? regs_q[usr_ra] : '0;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan_en
        assign chan_en[c] = regs_q[c][0];
    end

endmodule

// File: rtl/hcr_ctrl.sv
module hcr_ctrl
    import hcr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_not_empty,
    input  logic [BYTE_W-1:0] rx_data,
    output logic              rx_rd,
    input  logic              tx_full,
    output logic [BYTE_W-1:0] tx_data,
    output logic              tx_wr,
    input  logic              smp_not_empty,
    input  logic [BYTE_W-1:0] smp_data,
    output logic              smp_rd,
    input  logic              host_wr_ok,
    input  logic [BYTE_W-1:0] rf_rdata,
    output logic              rf_we,
    output logic [BYTE_W-1:0] rf_addr,
    output logic [BYTE_W-1:0] rf_wdata,
    output logic              addr_err,
    output logic              op_err
);

    ctrl_s q, d;

    always_comb begin
        d       = q;
        rx_rd   = 1'b0;
        tx_wr   = 1'b0;
        tx_data = q.rdata;
        smp_rd  = 1'b0;
        rf_we   = 1'b0;
        case (q.st)
            ST_IDLE: begin
                if (rx_not_empty) begin
                    d.st = ST_TAKE_OP;
                end else if (smp_not_empty) begin
                    d.st = ST_DRAIN;
                end
            end
            ST_TAKE_OP: begin
                if (rx_not_empty) begin
                    rx_rd = 1'b1;
                    d.opc = rx_data;
                    d.st  = ST_DECIDE;
                end
            end
            ST_DECIDE: begin
                if ((q.opc == OP_WR) || (q.opc == OP_RD)) begin
                    d.st = ST_GET_ADDR;
                end else begin
                    d.op_err = 1'b1;
                    d.st     = ST_FLUSH;
                end
            end
            ST_GET_ADDR: begin
                if (rx_not_empty) begin
                    rx_rd  = 1'b1;
                    d.addr = rx_data;
                    d.st   = (q.opc == OP_WR) ? ST_GET_DATA : ST_RD_REG;
                end
            end
            ST_GET_DATA: begin
                if (rx_not_empty) begin
                    rx_rd   = 1'b1;
                    d.wdata = rx_data;
                    d.st    = ST_WR_REG;
                end
            end
            ST_WR_REG: begin
                if (host_wr_ok) begin
                    rf_we = 1'b1;
                end else begin
                    d.addr_err = 1'b1;
                end
                d.st = ST_IDLE;
            end
            ST_RD_REG: begin
                d.rdata = rf_rdata;
                d.st    = ST_SEND;
            end
            ST_SEND: begin
                if (!tx_full) begin
                    tx_wr = 1'b1;
                    d.st  = ST_IDLE;
                end
            end
            ST_FLUSH: begin
                if (rx_not_empty) begin
                    rx_rd = 1'b1;
                end else begin
                    d.st = ST_IDLE;
                end
            end
            ST_DRAIN: begin
                if (rx_not_empty || !smp_not_empty) begin
                    d.st = ST_IDLE;
                end else if (!tx_full) begin
                    smp_rd  = 1'b1;
                    tx_wr   = 1'b1;
                    tx_data = smp_data;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, default: '0};
        end else begin
            q <= d;
        end
    end

    assign rf_addr  = q.addr;
    assign rf_wdata = q.wdata;
    assign addr_err = q.addr_err;
    assign op_err   = q.op_err;

endmodule

// File: rtl/host_cmd_regbank.sv
module host_cmd_regbank
    import hcr_pkg::*;
#(
    parameter int GEN_N = 28,
    parameter int WIN_N = 25,
    localparam int NUM_CH = 2,
    localparam int IDX_W  = $clog2(WIN_N)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_not_empty,
    input  logic [7:0]        rx_data,
    output logic              rx_rd,
    input  logic              tx_full,
    output logic [7:0]        tx_data,
    output logic              tx_wr,
    input  logic              smp_not_empty,
    input  logic [7:0]        smp_data,
    output logic              smp_rd,
    input  logic              usr_we,
    input  logic              usr_ch,
    input  logic [IDX_W-1:0]  usr_idx,
    input  logic [7:0]        usr_wdata,
    output logic [7:0]        usr_rdata,
    output logic [NUM_CH-1:0] chan_en,
    output logic              addr_err,
    output logic              op_err
);

    logic              host_wr_ok;
    logic              rf_we;
    logic [BYTE_W-1:0] rf_addr;
    logic [BYTE_W-1:0] rf_wdata;
    logic [BYTE_W-1:0] rf_rdata;

    hcr_ctrl i_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .rx_not_empty (rx_not_empty),
        .rx_data      (rx_data),
        .rx_rd        (rx_rd),
        .tx_full      (tx_full),
        .tx_data      (tx_data),
        .tx_wr        (tx_wr),
        .smp_not_empty(smp_not_empty),
        .smp_data     (smp_data),
        .smp_rd       (smp_rd),
        .host_wr_ok   (host_wr_ok),
        .rf_rdata     (rf_rdata),
        .rf_we        (rf_we),
        .rf_addr      (rf_addr),
        .rf_wdata     (rf_wdata),
        .addr_err     (addr_err),
        .op_err       (op_err)
    );

    hcr_region_decode #(
        .GEN_N(GEN_N),
        .WIN_N(WIN_N)
    ) i_decode (
        .addr      (rf_addr),
        .host_wr_ok(host_wr_ok)
    );

    hcr_regfile #(
        .GEN_N (GEN_N),
        .WIN_N (WIN_N),
        .NUM_CH(NUM_CH),
        .IDX_W (IDX_W)
    ) i_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .host_we   (rf_we),
        .host_addr (rf_addr),
        .host_wdata(rf_wdata),
        .host_rdata(rf_rdata),
        .usr_we    (usr_we),
        .usr_ch    (usr_ch),
        .usr_idx   (usr_idx),
        .usr_wdata (usr_wdata),
        .usr_rdata (usr_rdata),
        .chan_en   (chan_en)
    );

endmodule

// File: rtl/hcr_chk.sv
module hcr_chk (
    input logic clk,
    input logic rst_n,
    input logic rx_not_empty,
    input logic rx_rd,
    input logic tx_full,
    input logic tx_wr,
    input logic smp_not_empty,
    input logic smp_rd,
    input logic addr_err,
    input logic op_err
);

    // R5
    rx_pop_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_rd |-> rx_not_empty);

    // R6
    tx_push_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_wr |-> !tx_full);

    // R7
    smp_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        smp_rd |-> (tx_wr && smp_not_empty));

    // R8
    host_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        smp_rd |-> !rx_not_empty);

    // R3
    addr_err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        addr_err |=> addr_err);

    // R4
    op_err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_err |=> op_err);

endmodule

bind host_cmd_regbank hcr_chk i_hcr_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .rx_not_empty (rx_not_empty),
    .rx_rd        (rx_rd),
    .tx_full      (tx_full),
    .tx_wr        (tx_wr),
    .smp_not_empty(smp_not_empty),
    .smp_rd       (smp_rd),
    .addr_err     (addr_err),
    .op_err       (op_err)
);

// File: tb/test_host_cmd_regbank.sv
`timescale 1ns/1ps
module test_host_cmd_regbank;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_rd, tx_wr, smp_rd, tx_full = 1'b0;
    logic [7:0] tx_data, smp_data, rx_data, usr_rdata;
    logic       usr_we = 1'b0, usr_ch = 1'b0;
    logic [4:0] usr_idx = '0;
    logic [7:0] usr_wdata = '0;
    logic [1:0] chan_en;
    logic       addr_err, op_err;

    logic [7:0] rx_mem [256];
    logic [7:0] rx_wp = '0, rx_rp = '0;
    logic [7:0] sm_mem [256];
    logic [7:0] sm_wp = '0, sm_rp = '0;
    logic [7:0] tx_log [256];
    int         tx_cnt = 0;
    int         n_chk = 0, n_err = 0;

    wire rx_not_empty  = (rx_wp != rx_rp);
    wire smp_not_empty = (sm_wp != sm_rp);
    assign rx_data  = rx_mem[rx_rp];
    assign smp_data = sm_mem[sm_rp];

    always #4 clk = ~clk;

    always @(posedge clk) begin
        if (rx_rd)  rx_rp <= rx_rp + 8'd1;
        if (smp_rd) sm_rp <= sm_rp + 8'd1;
        if (tx_wr) begin
            tx_log[tx_cnt[7:0]] <= tx_data;
            tx_cnt <= tx_cnt + 1;
        end
    end

    host_cmd_regbank i_host_cmd_regbank (
        .clk(clk), .rst_n(rst_n),
        .rx_not_empty(rx_not_empty), .rx_data(rx_data), .rx_rd(rx_rd),
        .tx_full(tx_full), .tx_data(tx_data), .tx_wr(tx_wr),
        .smp_not_empty(smp_not_empty), .smp_data(smp_data), .smp_rd(smp_rd),
        .usr_we(usr_we), .usr_ch(usr_ch), .usr_idx(usr_idx),
        .usr_wdata(usr_wdata), .usr_rdata(usr_rdata),
        .chan_en(chan_en), .addr_err(addr_err), .op_err(op_err)
    );

    // {address, write data, expected read-back, expected addr_err}
    localparam logic [24:0] VEC [10] = '{
        {8'd0,   8'h01, 8'h01, 1'b0},
        {8'd1,   8'hFF, 8'hFF, 1'b0},
        {8'd27,  8'hA5, 8'hA5, 1'b0},
        {8'd53,  8'h3C, 8'h3C, 1'b0},
        {8'd77,  8'hC3, 8'hC3, 1'b0},
        {8'd103, 8'h5A, 8'h5A, 1'b0},
        {8'd127, 8'h7E, 8'h7E, 1'b0},
        {8'd52,  8'h99, 8'h00, 1'b1},
        {8'd78,  8'h12, 8'h00, 1'b1},
        {8'd200, 8'h34, 8'h00, 1'b1}
    };

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic push(input logic [7:0] b);
        rx_mem[rx_wp] = b;
        rx_wp = rx_wp + 8'd1;
    endtask

    task automatic push_smp(input logic [7:0] b);
        sm_mem[sm_wp] = b;
        sm_wp = sm_wp + 8'd1;
    endtask

    task automatic host_write(input logic [7:0] a, input logic [7:0] v);
        @(negedge clk);
        push(8'h01); push(a); push(v);
        settle(12);
    endtask

    task automatic host_read(input logic [7:0] a, output logic [7:0] v, output int n);
        int start;
        start = tx_cnt;
        @(negedge clk);
        push(8'h02); push(a);
        for (int k = 0; k < 60 && tx_cnt == start; k++) @(negedge clk);
        settle(4);
        v = tx_log[start[7:0]];
        n = tx_cnt - start;
    endtask

    task automatic usr_write(input logic ch, input logic [4:0] idx, input logic [7:0] v);
        @(negedge clk);
        usr_we = 1'b1; usr_ch = ch; usr_idx = idx; usr_wdata = v;
        @(negedge clk);
        usr_we = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: run did not finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        logic [7:0] v;
        int         n;
        int         start;

        settle(3);
        // R11: reset state
        chk(chan_en == 2'b00 && !addr_err && !op_err, "R11 reset flags", {chan_en, addr_err, op_err}, 0);
        chk(!rx_rd && !tx_wr && !smp_rd, "R11 reset strobes", {rx_rd, tx_wr, smp_rd}, 0);
        @(negedge clk);
        rst_n = 1'b1;
        settle(2);

        for (int i = 0; i < 10; i++) begin
            host_write(VEC[i][24:17], VEC[i][16:9]);
            host_read(VEC[i][24:17], v, n);
            if (VEC[i][0]) begin
                chk(v == VEC[i][8:1], "R3 illegal write read-back", v, VEC[i][8:1]);
                chk(addr_err == 1'b1, "R3 addr_err", addr_err, 1);
            end else begin
                chk(v == VEC[i][8:1], "R2 read-back", v, VEC[i][8:1]);
                chk(addr_err == 1'b0, "R2 no addr_err", addr_err, 0);
            end
            chk(n == 1, "R1 one response per read", n, 1);
            if (i == 1) chk(chan_en == 2'b11, "R9 both enables", chan_en, 2'b11);
        end

        // R3: neighbouring registers untouched by rejected writes
        host_read(8'd77, v, n);
        chk(v == 8'hC3, "R3 neighbour 77 intact", v, 8'hC3);
        host_read(8'd103, v, n);
        chk(v == 8'h5A, "R3 neighbour 103 intact", v, 8'h5A);

        // R9: only bit 0 drives the enable
        host_write(8'd1, 8'hFE);
        chk(chan_en == 2'b01, "R9 bit0 only", chan_en, 2'b01);

        // R10: user side port
        usr_write(1'b0, 5'd0, 8'h66);
        host_read(8'd28, v, n);
        chk(v == 8'h66, "R10 ch1 user write", v, 8'h66);
        usr_write(1'b1, 5'd24, 8'h77);
        host_read(8'd102, v, n);
        chk(v == 8'h77, "R10 ch2 user write last offset", v, 8'h77);
        usr_write(1'b0, 5'd25, 8'h88);
        host_read(8'd53, v, n);
        chk(v == 8'h3C, "R10 offset 25 ignored", v, 8'h3C);
        @(negedge clk);
        usr_ch = 1'b0; usr_idx = 5'd0;
        @(negedge clk);
        chk(usr_rdata == 8'h3C, "R10 ch1 user read", usr_rdata, 8'h3C);
        usr_ch = 1'b1; usr_idx = 5'd0;
        @(negedge clk);
        chk(usr_rdata == 8'h5A, "R10 ch2 user read", usr_rdata, 8'h5A);
        usr_ch = 1'b0; usr_idx = 5'd25;
        @(negedge clk);
        chk(usr_rdata == 8'h00, "R10 offset 25 reads zero", usr_rdata, 0);

        // R4: unknown opcode discarded
        chk(op_err == 1'b0, "R4 op_err clear before", op_err, 0);
        @(negedge clk);
        push(8'h07); push(8'd27); push(8'hFF);
        settle(20);
        chk(op_err == 1'b1, "R4 op_err set", op_err, 1);
        chk(rx_wp == rx_rp, "R4 packet flushed", rx_rp, rx_wp);
        host_read(8'd27, v, n);
        chk(v == 8'hA5, "R4 no register change", v, 8'hA5);

        // R6: response held while bridge full
        tx_full = 1'b1;
        start = tx_cnt;
        @(negedge clk);
        push(8'h02); push(8'd27);
        settle(20);
        chk(tx_cnt == start, "R6 no push while full", tx_cnt - start, 0);
        tx_full = 1'b0;
        settle(6);
        chk(tx_cnt == start + 1 && tx_log[start[7:0]] == 8'hA5, "R6 response after full", tx_log[start[7:0]], 8'hA5);

        // R7: sample draining in order
        start = tx_cnt;
        @(negedge clk);
        push_smp(8'h11); push_smp(8'h22); push_smp(8'h33);
        settle(20);
        chk(tx_cnt == start + 3, "R7 sample count", tx_cnt - start, 3);
        chk(tx_log[start[7:0]] == 8'h11 && tx_log[8'(start + 1)] == 8'h22 &&
            tx_log[8'(start + 2)] == 8'h33, "R7 sample order", tx_log[8'(start + 2)], 8'h33);
        chk(sm_wp == sm_rp, "R7 sample FIFO emptied", sm_rp, sm_wp);

        // R8: host command overtakes stalled draining
        tx_full = 1'b1;
        start = tx_cnt;
        @(negedge clk);
        push_smp(8'h44); push_smp(8'h55);
        settle(5);
        push(8'h02); push(8'd53);
        settle(20);
        chk(sm_wp != sm_rp, "R8 no sample taken while full", sm_rp, sm_wp);
        tx_full = 1'b0;
        settle(20);
        chk(tx_cnt == start + 3, "R8 total bytes", tx_cnt - start, 3);
        chk(tx_log[start[7:0]] == 8'h3C, "R8 response first", tx_log[start[7:0]], 8'h3C);
        chk(tx_log[8'(start + 1)] == 8'h44 && tx_log[8'(start + 2)] == 8'h55,
            "R8 draining resumed", tx_log[8'(start + 2)], 8'h55);

        // R5: every host byte popped exactly once
        chk(rx_wp == rx_rp, "R5 all host bytes consumed", rx_rp, rx_wp);

        // R11: reset mid-run
        @(negedge clk);
        rst_n = 1'b0;
        settle(2);
        chk(chan_en == 2'b00 && !addr_err && !op_err, "R11 flags after reset", {chan_en, addr_err, op_err}, 0);
        rst_n = 1'b1;
        settle(2);
        host_read(8'd27, v, n);
        chk(v == 8'h00, "R11 registers cleared", v, 0);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule